// File: doc/BRIEF.md
# Banked Nibble-Register Calendar Clock

This block is a real-time calendar counter that a processor reaches through a small register window. Each decimal digit of the time and date is kept as a separate 4-bit BCD register. The digits are seconds, minutes, hours, day of week, day of month, month and a four-digit year. The window has sixteen register indices. Index N sits at byte address 4×N, and only the low nibble of an access carries data.

Three banks share the window. A two-bit bank field in a control register, which stays visible in every bank, chooses between them: the running time, the alarm compare digits with their alarm control, and a timer control register. A one-pulse-per-second tick advances the calendar unless the stop bit is set. A busy bit marks the cycles after each advance, during which a multi-digit read may be inconsistent.

After each advance the alarm digits are compared with the new time. Bit 3 of an alarm tens digit, or of the alarm weekday, removes that field from the compare. A match sets a sticky flag, and the interrupt is raised while both the flag and its enable are set.

Top module: `nibble_cal_rtc`

## Requirements
- R1: After reset the control register reads 0 (time bank, running, not busy), every time digit reads 0 except day-units and month-units, which read 1, and irq is low.
- R2: The register index is bus_addr[5:2], with four byte addresses per index. An access with bus_addr[1:0] not zero, or any higher address bit set, is not decoded: a read returns 0 and a write changes nothing.
- R3: Index 0xF is the control register in every bank. Bit 0 is busy (read-only), bit 1 is stop, and bits 3:2 are the bank (0 time, 1 alarm, 2 timer). In bank 3 every other index reads 0.
- R4: A tick_1hz pulse while stop=0 advances the seconds by one at that clock edge. While stop=1 the digits hold.
- R5: In bank 0, indices 0x0–0xE are s1, s10, m1, m10, h1, h10, weekday, d1, d10, mon1, mon10, y1, y10, y100, y1000. They accept writes only while stop=1, and writes made while the clock runs are ignored.
- R6: Seconds and minutes roll over from 59 to 00, hours from 23 to 00, and the weekday from 6 to 0 on each day carry.
- R7: The day rolls over to 01 after the last day of the month: 31, 30 for April, June, September and November, and for February 29 when the year is divisible by 4, otherwise 28.
- R8: Month 12 rolls over to 01 and carries into the four BCD year digits (for example 2099 becomes 2100).
- R9: busy reads 1 for BUSY_CYC clock cycles after each counting tick and 0 otherwise.
- R10: In bank 1, indices 0x0–0x8 hold the alarm s1, s10, m1, m10, h1, h10, weekday, d1 and d10. One cycle after an advance, the flag (bank 1 index 0xE, bit 1) is set if every enabled field equals the new time, and seconds compare as a full two-digit value.
- R11: Bit 3 of an alarm tens digit (s10, m10, h10, d10) or of the alarm weekday excludes that whole field from the compare.
- R12: Bank 1 index 0xE bit 0 is the alarm enable, and irq = flag AND enable. Writing 0 to bit 1 clears the flag, and writing 1 leaves it unchanged.
- R13: Bank 2 index 0xE bit 0 is a stored timer enable. Bit 1, the timer flag, reads 0, and the other bank 2 indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | Write when set together with bus_sel |
| bus_addr | input | ADDR_W | Byte address, index in bits 5:2 |
| bus_wdata | input | 4 | Write nibble |
| bus_rdata | output | 4 | Read nibble of the addressed register (combinational) |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
A wrong carry in the digit chain shows only at the tick that crosses the affected boundary. The bench therefore places the time one second before each rollover and reads every digit back right after the advance, so an error in a month length, a leap decision or a year carry shows up within a few cycles of that single tick. A fault in the alarm compare or the don't-care bits shows up as a wrong flag or irq two cycles after the tick. A fault in the write gating or the bank decode shows up on the next read-back in the same bank. Busy is sampled one cycle after a tick and again after the window has closed.

// File: rtl/ncal_pkg.sv
package ncal_pkg;
  localparam int NIB_W      = 4;
  localparam int NUM_DIGITS = 15;

  localparam int IX_SEC1   = 0;
  localparam int IX_SEC10  = 1;
  localparam int IX_MIN1   = 2;
  localparam int IX_MIN10  = 3;
  localparam int IX_HR1    = 4;
  localparam int IX_HR10   = 5;
  localparam int IX_WDAY   = 6;
  localparam int IX_DAY1   = 7;
  localparam int IX_DAY10  = 8;
  localparam int IX_MON1   = 9;
  localparam int IX_MON10  = 10;
  localparam int IX_YR1    = 11;
  localparam int IX_YR10   = 12;
  localparam int IX_YR100  = 13;
  localparam int IX_YR1000 = 14;

  localparam logic [3:0] IX_AUX  = 4'hE;
  localparam logic [3:0] IX_CTRL = 4'hF;

  typedef enum logic [1:0] {
    BANK_TIME  = 2'd0,
    BANK_ALARM = 2'd1,
    BANK_TIMER = 2'd2,
    BANK_NONE  = 2'd3
  } bank_e;

  // {carry, next digit}: wraps to zero past lim
  function automatic logic [NIB_W:0] bcd_inc(input logic [NIB_W-1:0] v,
                                             input logic [NIB_W-1:0] lim);
    if (v >= lim) return {1'b1, {NIB_W{1'b0}}};
    return {1'b0, v + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_bin(input logic [NIB_W-1:0] tens,
                                         input logic [NIB_W-1:0] ones);
    return ({4'd0, tens} * 8'd10) + {4'd0, ones};
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'd2:                    return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/ncal_ctrl.sv
module ncal_ctrl #(
  parameter int BUSY_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_bits,   // {bank[1:0], stop}
  output logic       stop,
  output logic [1:0] bank,
  output logic       busy,
  output logic       adv,
  output logic       check
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          stop_nxt;
  logic [1:0]    bank_nxt;

  assign adv  = tick && !stop;
  assign busy = (cnt != '0);

  always_comb begin
    stop_nxt = stop;
    bank_nxt = bank;
    if (wr_en) begin
      stop_nxt = wr_bits[0];
      bank_nxt = wr_bits[2:1];
    end
    if (adv)            cnt_nxt = CW'(BUSY_CYC);
    else if (cnt != '0) cnt_nxt = cnt - 1'b1;
    else                cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop  <= 1'b0;
      bank  <= 2'd0;
      cnt   <= '0;
      check <= 1'b0;
    end else begin
      if (wr_en) begin
        stop <= stop_nxt;
        bank <= bank_nxt;
      end
      if (adv || busy) cnt <= cnt_nxt;
      check <= adv;
    end
  end

  p_busy_after_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> busy);
  p_check_after_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> check);
  p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(bank) && $stable(stop)));
endmodule

// File: rtl/ncal_time_core.sv
module ncal_time_core
  import ncal_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int ND = NUM_DIGITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   stopped,
  input  logic                   wr_en,
  input  logic [3:0]             wr_idx,
  input  logic [NW-1:0]          wr_nib,
  output logic [ND-1:0][NW-1:0]  digits
);
  logic [ND-1:0][NW-1:0] nxt;
  logic [ND-1:0]         wr_hit;
  logic                  upd, cy;
  logic [NW:0]           st;
  logic [7:0]            day_v, mon_v, mlen;
  logic [4:0]            leap_sum;
  logic                  leap;

  for (genvar g = 0; g < ND; g++) begin : g_hit
    assign wr_hit[g] = wr_en && stopped && (wr_idx == 4'(g));
  end

  // 10 = 2 mod 4, so the last two digits decide divisibility by 4
  assign leap_sum = {digits[IX_YR10][0], 1'b0} + {1'b0, digits[IX_YR1]};
  assign leap     = (leap_sum[1:0] == 2'b00);
  assign day_v    = bcd_bin(digits[IX_DAY10], digits[IX_DAY1]);
  assign mon_v    = bcd_bin(digits[IX_MON10], digits[IX_MON1]);
  assign mlen     = month_len(mon_v, leap);
  assign upd      = adv || (|wr_hit);

  always_comb begin
    nxt = digits;
    cy  = 1'b0;
    st  = '0;
    if (adv) begin
      st = bcd_inc(digits[IX_SEC1], 4'd9);
      nxt[IX_SEC1] = st[NW-1:0];
      cy = st[NW];
      if (cy) begin
        st = bcd_inc(digits[IX_SEC10], 4'd5);
        nxt[IX_SEC10] = st[NW-1:0];
        cy = st[NW];
      end
      if (cy) begin
        st = bcd_inc(digits[IX_MIN1], 4'd9);
        nxt[IX_MIN1] = st[NW-1:0];
        cy = st[NW];
      end
      if (cy) begin
        st = bcd_inc(digits[IX_MIN10], 4'd5);
        nxt[IX_MIN10] = st[NW-1:0];
        cy = st[NW];
      end
      if (cy) begin
        if (digits[IX_HR10] >= 4'd2 && digits[IX_HR1] >= 4'd3) begin
          nxt[IX_HR1]  = '0;
          nxt[IX_HR10] = '0;
        end else begin
          st = bcd_inc(digits[IX_HR1], 4'd9);
          nxt[IX_HR1] = st[NW-1:0];
          if (st[NW]) nxt[IX_HR10] = digits[IX_HR10] + 4'd1;
          cy = 1'b0;
        end
      end
      if (cy) begin
        nxt[IX_WDAY] = (digits[IX_WDAY] >= 4'd6) ? 4'd0 : digits[IX_WDAY] + 4'd1;
        if (day_v >= mlen) begin
          nxt[IX_DAY1]  = 4'd1;
          nxt[IX_DAY10] = 4'd0;
        end else begin
          st = bcd_inc(digits[IX_DAY1], 4'd9);
          nxt[IX_DAY1] = st[NW-1:0];
          if (st[NW]) nxt[IX_DAY10] = digits[IX_DAY10] + 4'd1;
          cy = 1'b0;
        end
      end
      if (cy) begin
        if (mon_v >= 8'd12) begin
          nxt[IX_MON1]  = 4'd1;
          nxt[IX_MON10] = 4'd0;
        end else begin
          st = bcd_inc(digits[IX_MON1], 4'd9);
          nxt[IX_MON1] = st[NW-1:0];
          if (st[NW]) nxt[IX_MON10] = digits[IX_MON10] + 4'd1;
          cy = 1'b0;
        end
      end
      for (int k = IX_YR1; k <= IX_YR1000; k++) begin
        if (cy) begin
          st = bcd_inc(digits[k], 4'd9);
          nxt[k] = st[NW-1:0];
          cy = st[NW];
        end
      end
    end else begin
      for (int k = 0; k < ND; k++) begin
        if (wr_hit[k]) nxt[k] = wr_nib;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digits           <= '0;
      digits[IX_DAY1]  <= 4'd1;
      digits[IX_MON1]  <= 4'd1;
    end else if (upd) begin
      digits <= nxt;
    end
  end

  p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !adv && !wr_en) |=> $stable(digits));
  p_sec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && digits[IX_SEC1] < 4'd9) |=> (digits[IX_SEC1] == $past(digits[IX_SEC1]) + 4'd1));
  p_run_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !adv) |=> $stable(digits));
endmodule

// File: rtl/ncal_alarm.sv
module ncal_alarm
  import ncal_pkg::*;
#(
  parameter int NW = NIB_W,
  parameter int NA = IX_DAY10 + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   check,
  input  logic                   reg_wr,
  input  logic                   ctl_wr,
  input  logic [3:0]             wr_idx,
  input  logic [NW-1:0]          wr_nib,
  input  logic [NA-1:0][NW-1:0]  now,
  input  logic [3:0]             rd_idx,
  output logic [NW-1:0]          rd_nib,
  output logic                   irq
);
  logic [NA-1:0][NW-1:0] areg, areg_nxt;
  logic [NA-1:0]         hit;
  logic                  aie, af, aie_nxt, af_nxt, match;

  function automatic logic pair_ok(input logic [NW-1:0] at, input logic [NW-1:0] ao,
                                   input logic [NW-1:0] tt, input logic [NW-1:0] to);
    return at[NW-1] || ((tt == {1'b0, at[NW-2:0]}) && (to == ao));
  endfunction

  for (genvar g = 0; g < NA; g++) begin : g_areg
    assign hit[g]      = reg_wr && (wr_idx == 4'(g));
    assign areg_nxt[g] = hit[g] ? wr_nib : areg[g];
  end

  assign match =
    pair_ok(areg[IX_SEC10], areg[IX_SEC1], now[IX_SEC10], now[IX_SEC1]) &&
    pair_ok(areg[IX_MIN10], areg[IX_MIN1], now[IX_MIN10], now[IX_MIN1]) &&
    pair_ok(areg[IX_HR10],  areg[IX_HR1],  now[IX_HR10],  now[IX_HR1])  &&
    pair_ok(areg[IX_DAY10], areg[IX_DAY1], now[IX_DAY10], now[IX_DAY1]) &&
    (areg[IX_WDAY][NW-1] || (now[IX_WDAY] == {1'b0, areg[IX_WDAY][NW-2:0]}));

  always_comb begin
    aie_nxt = ctl_wr ? wr_nib[0] : aie;
    if (check && match)          af_nxt = 1'b1;
    else if (ctl_wr && !wr_nib[1]) af_nxt = 1'b0;
    else                         af_nxt = af;
  end

  always_comb begin
    rd_nib = '0;
    for (int k = 0; k < NA; k++) begin
      if (rd_idx == 4'(k)) rd_nib = areg[k];
    end
    if (rd_idx == IX_AUX) rd_nib = {2'b00, af, aie};
  end

  assign irq = af && aie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areg <= '0;
      aie  <= 1'b0;
      af   <= 1'b0;
    end else begin
      if (reg_wr) areg <= areg_nxt;
      if (ctl_wr) aie  <= aie_nxt;
      af <= af_nxt;
    end
  end

  p_flag_rise_on_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(af) |-> $past(check));
  p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wr_nib[1] && !check) |=> !af);
  p_enable_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (aie == $past(wr_nib[0])));
endmodule

// File: rtl/nibble_cal_rtc.sv
module nibble_cal_rtc
  import ncal_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int IDX_LSB = 2;
  localparam int NA      = IX_DAY10 + 1;

  logic [1:0]                    rst_pipe;
  logic                          rst_sync_n;
  logic [3:0]                    idx;
  logic                          decoded, wr;
  logic                          stop, busy, adv, check;
  logic [1:0]                    bank;
  logic [NUM_DIGITS-1:0][NIB_W-1:0] digits;
  logic [NIB_W-1:0]              t_rd, a_rd, rd_mux;
  logic                          tmr_en, tmr_en_nxt, tmr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign idx     = bus_addr[IDX_LSB +: 4];
  assign decoded = (bus_addr[IDX_LSB-1:0] == '0) && ((bus_addr >> (IDX_LSB + 4)) == '0);
  assign wr      = bus_sel && bus_we && decoded;

  ncal_ctrl #(.BUSY_CYC(BUSY_CYC)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick_1hz),
    .wr_en   (wr && (idx == IX_CTRL)),
    .wr_bits (bus_wdata[3:1]),
    .stop    (stop),
    .bank    (bank),
    .busy    (busy),
    .adv     (adv),
    .check   (check)
  );

  ncal_time_core time_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .adv     (adv),
    .stopped (stop),
    .wr_en   (wr && (bank == BANK_TIME)),
    .wr_idx  (idx),
    .wr_nib  (bus_wdata),
    .digits  (digits)
  );

  ncal_alarm #(.NA(NA)) alarm_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .check  (check),
    .reg_wr (wr && (bank == BANK_ALARM)),
    .ctl_wr (wr && (bank == BANK_ALARM) && (idx == IX_AUX)),
    .wr_idx (idx),
    .wr_nib (bus_wdata),
    .now    (digits[NA-1:0]),
    .rd_idx (idx),
    .rd_nib (a_rd),
    .irq    (irq)
  );

  assign tmr_wr     = wr && (bank == BANK_TIMER) && (idx == IX_AUX);
  assign tmr_en_nxt = tmr_wr ? bus_wdata[0] : tmr_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tmr_en <= 1'b0;
    else if (tmr_wr)  tmr_en <= tmr_en_nxt;
  end

  always_comb begin
    t_rd = '0;
    for (int k = 0; k < NUM_DIGITS; k++) begin
      if (idx == 4'(k)) t_rd = digits[k];
    end
  end

  always_comb begin
    if (idx == IX_CTRL) rd_mux = {bank, stop, busy};
    else begin
      case (bank_e'(bank))
        BANK_TIME:  rd_mux = t_rd;
        BANK_ALARM: rd_mux = a_rd;
        BANK_TIMER: rd_mux = (idx == IX_AUX) ? {3'b000, tmr_en} : '0;
        default:    rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata = decoded ? rd_mux : '0;

  p_undecoded_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !decoded |-> (bus_rdata == '0));
endmodule

// File: tb/nibble_cal_rtc_tb_top.sv
module nibble_cal_rtc_tb_top;
  localparam int BUSY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic [3:0] bus_rdata;
  logic       irq;

  always #4 clk = ~clk;   // 125 MHz

  nibble_cal_rtc #(.ADDR_W(6), .BUSY_CYC(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [3:0] rd;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic sb_rd  = 1'b0;
  bit   done   = 1'b0;

  // monitor: compares at the falling edge, mid-cycle
  always @(negedge clk) begin
    if (sb_rd && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (bus_rdata !== e.rd || irq !== e.irq) begin
        errors++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, bus_rdata, irq, e.rd, e.irq);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [3:0] val);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {idx, 2'b00}; bus_wdata = val;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic expect_addr(input logic [5:0] a, input logic [3:0] v,
                             input logic ei, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    e.rd = v; e.irq = ei; e.tag = tag;
    q.push_back(e);
    sb_rd = 1'b1;
    @(posedge clk); #1;
    sb_rd = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] idx, input logic [3:0] v,
                           input logic ei, input string tag);
    expect_addr({idx, 2'b00}, v, ei, tag);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tick_1hz = 1'b1;
    @(posedge clk); #1;
    tick_1hz = 1'b0;
  endtask

  // digits: year thousands..units, month, day, weekday, hh, mm, ss (bank 0, stopped)
  task automatic set_time(input logic [3:0] y3, y2, y1, y0, mo10, mo1, d10, d1,
                          wd, h10, h1, m10, m1, s10, s1);
    wr(4'h0, s1);  wr(4'h1, s10); wr(4'h2, m1);  wr(4'h3, m10);
    wr(4'h4, h1);  wr(4'h5, h10); wr(4'h6, wd);  wr(4'h7, d1);
    wr(4'h8, d10); wr(4'h9, mo1); wr(4'hA, mo10);
    wr(4'hB, y0);  wr(4'hC, y1);  wr(4'hD, y2);  wr(4'hE, y3);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    expect_rd(4'hF, 4'h0, 1'b0, "R1 control after reset");
    expect_rd(4'h0, 4'h0, 1'b0, "R1 seconds units after reset");
    expect_rd(4'h7, 4'h1, 1'b0, "R1 day units after reset");
    expect_rd(4'h9, 4'h1, 1'b0, "R1 month units after reset");
    expect_rd(4'hE, 4'h0, 1'b0, "R1 year thousands after reset");

    // R5 write while running ignored
    wr(4'h0, 4'h5);
    expect_rd(4'h0, 4'h0, 1'b0, "R5 running write ignored");

    // R4 tick advances
    tick(); idle(BUSY + 4);
    expect_rd(4'h0, 4'h1, 1'b0, "R4 tick advances seconds");

    // R9 busy window
    tick();
    expect_rd(4'hF, 4'h1, 1'b0, "R9 busy right after tick");
    idle(BUSY + 4);
    expect_rd(4'hF, 4'h0, 1'b0, "R9 busy cleared after window");

    // R2 address decode
    expect_addr(6'h01, 4'h0, 1'b0, "R2 misaligned read is zero");
    expect_rd(4'h0, 4'h2, 1'b0, "R2 aligned read of index 0");
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h3D; bus_wdata = 4'h6;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
    expect_rd(4'hF, 4'h0, 1'b0, "R2 misaligned control write ignored");

    // stop; R3 control readback
    wr(4'hF, 4'h2);
    expect_rd(4'hF, 4'h2, 1'b0, "R3 stop bit reads back");

    // R6 rollovers, R7 non-leap Feb, R4 stop holds
    set_time(4'd2, 4'd0, 4'd2, 4'd3, 4'd0, 4'd2, 4'd2, 4'd8, 4'd6,
             4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
    expect_rd(4'h6, 4'h6, 1'b0, "R5 stopped write accepted");
    tick(); idle(4);
    expect_rd(4'h0, 4'h9, 1'b0, "R4 stopped tick holds seconds");
    wr(4'hF, 4'h0);
    tick(); idle(BUSY + 2);
    expect_rd(4'h0, 4'h0, 1'b0, "R6 seconds units wrap");
    expect_rd(4'h1, 4'h0, 1'b0, "R6 seconds tens wrap");
    expect_rd(4'h3, 4'h0, 1'b0, "R6 minutes tens wrap");
    expect_rd(4'h4, 4'h0, 1'b0, "R6 hours units wrap");
    expect_rd(4'h5, 4'h0, 1'b0, "R6 hours tens wrap");
    expect_rd(4'h6, 4'h0, 1'b0, "R6 weekday 6 to 0");
    expect_rd(4'h7, 4'h1, 1'b0, "R7 Feb 28 non-leap to day 1");
    expect_rd(4'h9, 4'h3, 1'b0, "R7 month advances to March");

    // R7 leap Feb
    wr(4'hF, 4'h2);
    set_time(4'd2, 4'd0, 4'd2, 4'd4, 4'd0, 4'd2, 4'd2, 4'd8, 4'd1,
             4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'hF, 4'h0);
    tick(); idle(BUSY + 2);
    expect_rd(4'h7, 4'h9, 1'b0, "R7 leap Feb 29 units");
    expect_rd(4'h8, 4'h2, 1'b0, "R7 leap Feb 29 tens");
    expect_rd(4'h9, 4'h2, 1'b0, "R7 leap stays February");

    // R7 30-day month
    wr(4'hF, 4'h2);
    set_time(4'd2, 4'd0, 4'd2, 4'd3, 4'd0, 4'd4, 4'd3, 4'd0, 4'd2,
             4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'hF, 4'h0);
    tick(); idle(BUSY + 2);
    expect_rd(4'h7, 4'h1, 1'b0, "R7 April 30 to day 1");
    expect_rd(4'h8, 4'h0, 1'b0, "R7 April 30 day tens");
    expect_rd(4'h9, 4'h5, 1'b0, "R7 April to May");

    // R8 year carry
    wr(4'hF, 4'h2);
    set_time(4'd2, 4'd0, 4'd9, 4'd9, 4'd1, 4'd2, 4'd3, 4'd1, 4'd4,
             4'd2, 4'd3, 4'd5, 4'd9, 4'd5, 4'd9);
    wr(4'hF, 4'h0);
    tick(); idle(BUSY + 2);
    expect_rd(4'h9, 4'h1, 1'b0, "R8 month 12 to 1 units");
    expect_rd(4'hA, 4'h0, 1'b0, "R8 month 12 to 1 tens");
    expect_rd(4'hB, 4'h0, 1'b0, "R8 year units");
    expect_rd(4'hC, 4'h0, 1'b0, "R8 year tens");
    expect_rd(4'hD, 4'h1, 1'b0, "R8 year hundreds");
    expect_rd(4'hE, 4'h2, 1'b0, "R8 year thousands");

    // alarm setup: time 2024-05-15 wd3 10:20:29
    wr(4'hF, 4'h2);
    set_time(4'd2, 4'd0, 4'd2, 4'd4, 4'd0, 4'd5, 4'd1, 4'd5, 4'd3,
             4'd1, 4'd0, 4'd2, 4'd0, 4'd2, 4'd9);
    wr(4'hF, 4'h6);
    expect_rd(4'hF, 4'h6, 1'b0, "R3 bank 1 selected while stopped");
    wr(4'h0, 4'h0); wr(4'h1, 4'h3); wr(4'h2, 4'h0); wr(4'h3, 4'h2);
    wr(4'h4, 4'h0); wr(4'h5, 4'h1); wr(4'h6, 4'h8); wr(4'h7, 4'h0);
    wr(4'h8, 4'h8);
    wr(4'hE, 4'h1);
    expect_rd(4'hE, 4'h1, 1'b0, "R12 enable stored, no flag");
    expect_rd(4'h1, 4'h3, 1'b0, "R10 alarm register readback");
    wr(4'hF, 4'h4);
    tick(); idle(4);
    expect_rd(4'hE, 4'h3, 1'b1, "R10 alarm match sets flag and irq");
    wr(4'hE, 4'h3);
    expect_rd(4'hE, 4'h3, 1'b1, "R12 writing 1 to flag leaves it set");
    wr(4'hE, 4'h1);
    expect_rd(4'hE, 4'h1, 1'b0, "R12 writing 0 clears flag");
    tick(); idle(4);
    expect_rd(4'hE, 4'h1, 1'b0, "R10 seconds 31 vs 30 no match");

    // R11 minute don't-care
    wr(4'h3, 4'h8); wr(4'h2, 4'h9); wr(4'h0, 4'h2);
    tick(); idle(4);
    expect_rd(4'hE, 4'h3, 1'b1, "R11 minute field excluded");
    wr(4'hE, 4'h1);
    // R11 weekday compared when bit 3 clear
    wr(4'h6, 4'h4); wr(4'h0, 4'h3);
    tick(); idle(4);
    expect_rd(4'hE, 4'h1, 1'b0, "R11 weekday mismatch blocks match");
    // R12 flag without enable
    wr(4'hE, 4'h0);
    wr(4'h6, 4'h3); wr(4'h0, 4'h4);
    tick(); idle(4);
    expect_rd(4'hE, 4'h2, 1'b0, "R12 flag set but irq needs enable");
    wr(4'hE, 4'h3);
    expect_rd(4'hE, 4'h3, 1'b1, "R12 enable raises irq with pending flag");
    wr(4'hE, 4'h0);
    expect_rd(4'hE, 4'h0, 1'b0, "R12 clear flag and enable");

    // R13 timer bank
    wr(4'hF, 4'h8);
    expect_rd(4'hF, 4'h8, 1'b0, "R3 control visible in bank 2");
    wr(4'hE, 4'h3);
    expect_rd(4'hE, 4'h1, 1'b0, "R13 timer enable stored, flag reads 0");
    expect_rd(4'h0, 4'h0, 1'b0, "R13 other bank 2 index reads 0");

    // R3 bank 3
    wr(4'hF, 4'hC);
    expect_rd(4'hF, 4'hC, 1'b0, "R3 bank 3 control readback");
    expect_rd(4'h0, 4'h0, 1'b0, "R3 bank 3 index 0 reads 0");
    expect_rd(4'hE, 4'h0, 1'b0, "R3 bank 3 index E reads 0");

    idle(3);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: pending=%0d expected=0", q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule